// File: doc/BRIEF.md
# Modem Line Status and Loopback Unit

This unit holds the modem-control byte and the modem-status byte of a 16550-style serial port. Four modem input lines enter through a multi-flop synchroniser: clear-to-send, data-set-ready, ring indicator and carrier detect. The unit compares each freshly sampled set of lines with the previously held set and records every change in sticky delta flags. For the ring line, only the falling edge is recorded. A status read returns the held line states together with the delta flags, and the read clears the flags. The control byte drives the data-terminal-ready, request-to-send and two general-purpose outputs.

When the loopback bit of the control byte is set, the external outputs go inactive. A status read then reports the control outputs, cross-wired onto the line-state positions, and the delta flags read as zero. The unit keeps tracking the real lines underneath, and a read in this mode leaves the recorded deltas untouched. A single any-delta output feeds the interrupt logic. All lines and control bits are active high.

Top module: `mdm_link_unit`

## Requirements
- R1: After reset the status read is 0xB0 (carrier, data-set-ready and clear-to-send set, ring clear, no deltas) with all lines held at that pattern. The control read is 0x08. out2Out is high; dtrOut, rtsOut and out1Out are low. anyDelta is low.
- R2: Status bits 7:4 hold the synchronised lines as carrier (7), ring (6), data-set-ready (5) and clear-to-send (4). Delta bits 3, 1 and 0 (carrier, data-set-ready, clear-to-send) are set by any change of their line, as the XOR of old and new state. Once set, they stay set until cleared by a status read, even if the line returns to its old value.
- R3: Delta bit 2 is set only when the ring line goes from 1 to 0; a 0-to-1 change leaves it clear.
- R4: Outside loopback, a status read returns the current value. Bits 3:0 read as zero afterwards, while bits 7:4 are unchanged. A line change that lands on the cycle of the read is still recorded.
- R5: A control write keeps only data bits 4:0, and the control read has bits 7:5 at zero. Outside loopback, dtrOut follows bit 0, rtsOut bit 1, out1Out bit 2 and out2Out bit 3.
- R6: With control bit 4 set, a status read returns control bit 3 in bit 7, bit 2 in bit 6, bit 0 in bit 5 and bit 1 in bit 4, with bits 3:0 reading zero.
- R7: With control bit 4 set, dtrOut, rtsOut, out1Out and out2Out are all low.
- R8: In loopback a status read does not clear the recorded deltas, and line changes keep being tracked; both are visible once loopback is left.
- R9: anyDelta is high exactly when at least one of the four recorded delta flags is set, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Write strobe for the control byte |
| ctlWrData | input | 8 | Write data for the control byte |
| ctlRdData | output | 8 | Current control byte |
| staRdEn | input | 1 | Status read strobe; clears deltas outside loopback |
| staRdData | output | 8 | Status byte as seen by a read |
| ctsIn | input | 1 | Clear-to-send line, asynchronous |
| dsrIn | input | 1 | Data-set-ready line, asynchronous |
| riIn | input | 1 | Ring indicator line, asynchronous |
| dcdIn | input | 1 | Carrier detect line, asynchronous |
| dtrOut | output | 1 | Data-terminal-ready output |
| rtsOut | output | 1 | Request-to-send output |
| out1Out | output | 1 | General-purpose output 1 |
| out2Out | output | 1 | General-purpose output 2 |
| anyDelta | output | 1 | High while any delta flag is recorded |

## Verification
A line change applied between clock edges passes through two synchroniser flops and then the state and delta registers. It is therefore due on the third rising edge. The bench samples it half a cycle later, and one check confirms that it has not yet appeared after two edges. A control write takes effect at the next edge. The status and control read data are combinational, so they are sampled just after the strobes are set. A delta clear takes effect at the edge that ends the read. The bench makes every state change at a falling edge and samples only at a falling edge. For each of the 256 old-to-new line pairs, it first clears the deltas and then waits four edges, so that every result is settled when it is compared.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int LINE_W = 4;
  localparam int CTRL_W = 5;
  localparam int BYTE_W = 8;

  // line vector positions {carrier, ring, data-set-ready, clear-to-send}
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  // control byte positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;

  localparam logic [LINE_W-1:0] LINE_RST = 4'b1011;
  localparam logic [CTRL_W-1:0] CTRL_RST = 5'b01000;

  typedef struct packed {
    logic ctlLoad;
    logic deltaClr;
  } mdmStrobe_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int STAGES = 2,
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] pipe [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) pipe[gi] <= RST_VAL;
      else if (gi == 0) pipe[gi] <= asyncIn;
      else pipe[gi] <= pipe[(gi == 0) ? 0 : gi-1];
    end
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic       ctlWrEn,
  input  logic       staRdEn,
  input  logic       loopOn,
  output mdmStrobe_t stb
);
  always_comb begin
    stb.ctlLoad  = ctlWrEn;
    // a read only consumes deltas when it actually returned them
    stb.deltaClr = staRdEn && !loopOn;
  end
endmodule

// File: rtl/mdm_datapath.sv
module mdm_datapath
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mdmStrobe_t        stb,
  input  logic [CTRL_W-1:0] wrBits,
  input  logic [LINE_W-1:0] lineSync,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic [LINE_W-1:0] deltaQ,
  output logic [BYTE_W-1:0] staView
);
  logic [LINE_W-1:0] stateQ;
  logic [LINE_W-1:0] events;

  always_comb begin
    events        = stateQ ^ lineSync;
    events[L_RI]  = stateQ[L_RI] && !lineSync[L_RI];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= CTRL_RST;
      stateQ <= LINE_RST;
      deltaQ <= '0;
    end else begin
      if (stb.ctlLoad) ctrlQ <= wrBits;
      stateQ <= lineSync;
      deltaQ <= (stb.deltaClr ? '0 : deltaQ) | events;
    end
  end

  always_comb begin
    if (ctrlQ[C_LOOP])
      staView = {ctrlQ[C_OUT2], ctrlQ[C_OUT1], ctrlQ[C_DTR], ctrlQ[C_RTS], {LINE_W{1'b0}}};
    else
      staView = {stateQ, deltaQ};
  end

  AST_RI_FALL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deltaQ[L_RI]) |-> ($past(stateQ[L_RI]) && !stateQ[L_RI])); // R3

  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((~deltaQ & $past(deltaQ)) != '0) |-> $past(stb.deltaClr)); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.deltaClr && (lineSync == stateQ)) |=> (deltaQ == '0)); // R4

  AST_LOOP_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[C_LOOP] && (lineSync == stateQ)) |=> ((deltaQ & $past(deltaQ)) == $past(deltaQ))); // R8
endmodule

// File: rtl/mdm_link_unit.sv
module mdm_link_unit
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [BYTE_W-1:0] ctlWrData,
  output logic [BYTE_W-1:0] ctlRdData,
  input  logic              staRdEn,
  output logic [BYTE_W-1:0] staRdData,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              riIn,
  input  logic              dcdIn,
  output logic              dtrOut,
  output logic              rtsOut,
  output logic              out1Out,
  output logic              out2Out,
  output logic              anyDelta
);
  localparam int PAD_W = BYTE_W - CTRL_W;

  mdmStrobe_t        stb;
  logic [CTRL_W-1:0] ctrlQ;
  logic [LINE_W-1:0] deltaQ;
  logic [LINE_W-1:0] lineSync;
  logic              unusedHiBits;

  assign unusedHiBits = ^ctlWrData[BYTE_W-1:CTRL_W];

  mdm_sync #(.STAGES(SYNC_STAGES), .W(LINE_W), .RST_VAL(LINE_RST)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({dcdIn, riIn, dsrIn, ctsIn}),
    .syncOut(lineSync)
  );

  mdm_ctrl u_ctrl (
    .ctlWrEn(ctlWrEn), .staRdEn(staRdEn), .loopOn(ctrlQ[C_LOOP]), .stb(stb)
  );

  mdm_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrBits(ctlWrData[CTRL_W-1:0]), .lineSync(lineSync),
    .ctrlQ(ctrlQ), .deltaQ(deltaQ), .staView(staRdData)
  );

  assign ctlRdData = {{PAD_W{1'b0}}, ctrlQ};
  assign dtrOut    = ctrlQ[C_DTR]  && !ctrlQ[C_LOOP];
  assign rtsOut    = ctrlQ[C_RTS]  && !ctrlQ[C_LOOP];
  assign out1Out   = ctrlQ[C_OUT1] && !ctrlQ[C_LOOP];
  assign out2Out   = ctrlQ[C_OUT2] && !ctrlQ[C_LOOP];
  assign anyDelta  = |deltaQ;

  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdData[C_LOOP] |-> !(dtrOut || rtsOut || out1Out || out2Out)); // R7

  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    !ctlRdData[C_LOOP] |-> (anyDelta == (staRdData[LINE_W-1:0] != '0))); // R9
endmodule

// File: tb/sim_mdm_link_unit.sv
module sim_mdm_link_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = '0;
  logic staRdEn = 1'b0;
  logic [7:0] ctlRdData, staRdData;
  logic [3:0] pins = 4'b1011; // {carrier, ring, dsr, cts}
  logic dtrOut, rtsOut, out1Out, out2Out, anyDelta;
  int nVec = 0;
  int nBad = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  mdm_link_unit u0 (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .staRdEn(staRdEn), .staRdData(staRdData),
    .ctsIn(pins[0]), .dsrIn(pins[1]), .riIn(pins[2]), .dcdIn(pins[3]),
    .dtrOut(dtrOut), .rtsOut(rtsOut), .out1Out(out1Out), .out2Out(out2Out),
    .anyDelta(anyDelta)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtl(input logic [7:0] v);
    ctlWrData = v; ctlWrEn = 1'b1;
    cyc(1);
    ctlWrEn = 1'b0;
  endtask

  task automatic rdSta(output logic [7:0] v);
    staRdEn = 1'b1;
    #1 v = staRdData;
    cyc(1);
    staRdEn = 1'b0;
  endtask

  function automatic logic [3:0] expDelta(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] d;
    d = (o ^ n) & 4'b1011;
    d[2] = o[2] & ~n[2];
    return d;
  endfunction

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 status", staRdData, 8'hB0);
    chk("R1 control", ctlRdData, 8'h08);
    chk("R1 outputs", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h08);
    chk("R1 anyDelta", {7'b0, anyDelta}, 8'h00);

    // R2 latency: visible on the third edge, not the second
    pins = 4'b1010;
    cyc(2);
    chk("R2 not yet", staRdData, 8'hB0);
    cyc(1);
    chk("R2 due", staRdData, 8'hA1);
    rdSta(got);
    chk("R4 read value", got, 8'hA1);
    chk("R4 cleared", staRdData, 8'hA0);

    // R2 sticky: line goes back, delta stays
    pins = 4'b1011; cyc(4);
    pins = 4'b1010; cyc(4);
    chk("R2 sticky", staRdData, 8'hA1);
    rdSta(got);

    // R2 R3 R9 exhaustive old/new sweep
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        pins = o[3:0]; cyc(4);
        rdSta(got);
        pins = n[3:0]; cyc(4);
        chk("R9 anyDelta", {7'b0, anyDelta}, {7'b0, expDelta(o[3:0], n[3:0]) != 4'b0});
        rdSta(got);
        chk("R2_R3 sweep", got, {n[3:0], expDelta(o[3:0], n[3:0])});
        chk("R4 after read", staRdData, {n[3:0], 4'b0});
      end
    end

    // R4 change landing on the read edge is kept
    pins = 4'b0000; cyc(4); rdSta(got);
    pins = 4'b0001;
    cyc(2);
    staRdEn = 1'b1;
    cyc(1);
    staRdEn = 1'b0;
    chk("R4 same-cycle event", staRdData, 8'h11);
    rdSta(got);

    // R5 R6 R7 control sweep
    for (int m = 0; m < 32; m++) begin
      wrCtl({3'b111, m[4:0]});
      chk("R5 readback", ctlRdData, {3'b0, m[4:0]});
      if (m[4]) begin
        chk("R7 outputs idle", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, 8'h00);
        chk("R6 loop view", staRdData, {m[3], m[2], m[0], m[1], 4'b0});
      end else begin
        chk("R5 outputs", {4'b0, out2Out, out1Out, rtsOut, dtrOut}, {4'b0, m[3:0]});
        chk("R5 status normal", staRdData, 8'h10);
      end
    end

    // R8 loopback read keeps deltas; tracking continues
    wrCtl(8'h00);
    pins = 4'b0100; cyc(4);          // cts fall, ring rise: delta 0001
    wrCtl(8'h1F);
    chk("R9 anyDelta in loop", {7'b0, anyDelta}, 8'h01);
    rdSta(got);
    chk("R6 loop read deltas zero", got, 8'hF0);
    pins = 4'b0000; cyc(4);          // ring fall in loop: adds 0100
    rdSta(got);
    wrCtl(8'h00);
    chk("R8 deltas kept", staRdData, 8'h05);
    rdSta(got);
    chk("R8 cleared outside loop", staRdData, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule